// File: doc/BRIEF.md
# Branch Link and Count Register Unit

This unit keeps the two branch-side special registers of a 64-bit processor core: a return-address register (the link register) and a loop-count register. It sits beside the branch execution stage. When a branch asks for it, the unit records the address that follows the branch instruction as the return address. For counted conditional branches it decrements the count register and reports whether the branch condition on the counter holds. Both registers can also be written with a general-purpose value through a move-to port. Either register can supply the branch target address.

A single branch may decrement the counter and capture the return address in the same cycle. A move-to write that lands in the same cycle as a branch update of the same register takes priority over the branch update. The current register values are available on output ports so that the pipeline can read them back.

Top module: `blcr_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `lr_q` and `ctr_q` become zero.
- R2: A branch with `br_valid=1` and `br_link=1` sets `lr_q` to `cia + 4` (modulo 2^64) at the next edge.
- R3: A branch with `br_valid=1` and `br_dec=1` sets `ctr_q` to `ctr_q - 1` (modulo 2^64) at the next edge. A counter of 0 wraps to all ones.
- R4: `ctr_ok` is combinational. When `br_valid=1` and `br_dec=1`, it equals 1 if (`ctr_q - 1 == 0`) equals `br_zero_sense`. `br_zero_sense=1` means the branch is taken on zero and 0 means it is taken on nonzero. In every other case `ctr_ok` is 1.
- R5: `mt_valid=1` writes `mt_data` into the link register when `mt_sel=0`, or into the count register when `mt_sel=1`, at the next edge.
- R6: If a move-to write and a branch update target the same register in one cycle, that register takes `mt_data`. The other register still takes its branch update.
- R7: A branch with both `br_link=1` and `br_dec=1` updates both registers at the same edge.
- R8: `tgt_addr` is combinational. It equals `ctr_q` when `br_tgt_sel=1` and `lr_q` when `br_tgt_sel=0`, using the values held before this cycle's updates.
- R9: With `br_valid=0`, the inputs `br_link` and `br_dec` have no effect. A register that neither a branch nor a move-to writes keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch executes this cycle |
| br_link | input | 1 | Branch captures the return address |
| br_dec | input | 1 | Branch decrements and tests the counter |
| br_zero_sense | input | 1 | 1: condition holds on zero, 0: on nonzero |
| br_tgt_sel | input | 1 | Target source: 0 link, 1 count |
| cia | input | 64 | Address of the branch instruction |
| mt_valid | input | 1 | Move-to write this cycle |
| mt_sel | input | 1 | Move-to destination: 0 link, 1 count |
| mt_data | input | 64 | Move-to value |
| lr_q | output | 64 | Link register value |
| ctr_q | output | 64 | Count register value |
| ctr_ok | output | 1 | Counter branch condition result |
| tgt_addr | output | 64 | Branch target address from the selected register |

## Verification
The hardest case to reach from the ports is a branch that decrements the counter and captures the link address in the same cycle as a move-to write of one of those two registers. The check also needs the counter sitting at 1 or 0, so that the zero test and the wrap are both exercised. The stimulus first loads the counter with small values through the move-to port. It then issues combined branches while a move-to targets each register in turn. A long pseudo-random phase follows, in which move-to data is biased toward 0, 1 and 2 and every input combination is drawn often. A behavioural model compares the registers, the condition and the target address every cycle.

// File: rtl/blcr_pkg.sv
package blcr_pkg;

    typedef enum logic {
        SPR_LINK  = 1'b0,
        SPR_COUNT = 1'b1
    } spr_sel_e;

    typedef struct packed {
        logic     valid;
        logic     link;
        logic     dec;
        logic     zero_sense;
        spr_sel_e tgt;
    } br_ctl_t;

    typedef struct packed {
        logic     valid;
        spr_sel_e dest;
    } mt_ctl_t;

    function automatic logic cond_eval(input logic dec_en,
                                       input logic is_zero,
                                       input logic zero_sense);
        if (!dec_en)
            return 1'b1;
        return (is_zero == zero_sense);
    endfunction

endpackage

// File: rtl/blcr_link_reg.sv
module blcr_link_reg
    import blcr_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_en,
    input  logic [XLEN-1:0] cia,
    input  logic            mt_hit,
    input  logic [XLEN-1:0] mt_data,
    output logic [XLEN-1:0] lr_q
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] ret_addr;
    assign ret_addr = cia + STEP;

    always_ff @(posedge clk) begin
        if (rst)
            lr_q <= '0;
        else if (mt_hit)
            lr_q <= mt_data;
        else if (cap_en)
            lr_q <= ret_addr;
    end

    p_link_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !mt_hit) |=> lr_q == $past(cia) + STEP);
    p_mt_wins_link_r6: assert property (@(posedge clk) disable iff (rst)
        mt_hit |=> lr_q == $past(mt_data));
    p_link_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !mt_hit) |=> $stable(lr_q));
endmodule

// File: rtl/blcr_count_reg.sv
module blcr_count_reg
    import blcr_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_en,
    input  logic            zero_sense,
    input  logic            mt_hit,
    input  logic [XLEN-1:0] mt_data,
    output logic [XLEN-1:0] ctr_q,
    output logic            ctr_ok
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic [XLEN-1:0] ctr_dec;
    logic            dec_zero;

    assign ctr_dec  = ctr_q - ONE;
    assign dec_zero = (ctr_dec == '0);
    assign ctr_ok   = cond_eval(dec_en, dec_zero, zero_sense);

    always_ff @(posedge clk) begin
        if (rst)
            ctr_q <= '0;
        else if (mt_hit)
            ctr_q <= mt_data;
        else if (dec_en)
            ctr_q <= ctr_dec;
    end

    p_ctr_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !mt_hit) |=> ctr_q == $past(ctr_q) - ONE);
    p_mt_wins_ctr_r6: assert property (@(posedge clk) disable iff (rst)
        mt_hit |=> ctr_q == $past(mt_data));
    p_ctr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!dec_en && !mt_hit) |=> $stable(ctr_q));
    p_zero_cond_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !mt_hit && ctr_ok && zero_sense) |=> ctr_q == '0);
endmodule

// File: rtl/blcr_target_sel.sv
module blcr_target_sel
    import blcr_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  spr_sel_e        sel,
    input  logic [XLEN-1:0] lr_val,
    input  logic [XLEN-1:0] ctr_val,
    output logic [XLEN-1:0] tgt
);
    always_comb begin
        unique case (sel)
            SPR_COUNT: tgt = ctr_val;
            default:   tgt = lr_val;
        endcase
    end
endmodule

// File: rtl/blcr_unit.sv
module blcr_unit
    import blcr_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            br_valid,
    input  logic            br_link,
    input  logic            br_dec,
    input  logic            br_zero_sense,
    input  logic            br_tgt_sel,
    input  logic [XLEN-1:0] cia,
    input  logic            mt_valid,
    input  logic            mt_sel,
    input  logic [XLEN-1:0] mt_data,
    output logic [XLEN-1:0] lr_q,
    output logic [XLEN-1:0] ctr_q,
    output logic            ctr_ok,
    output logic [XLEN-1:0] tgt_addr
);
    br_ctl_t br;
    mt_ctl_t mt;
    logic    mt_link_hit;
    logic    mt_count_hit;

    assign br = '{valid: br_valid, link: br_link, dec: br_dec,
                  zero_sense: br_zero_sense, tgt: spr_sel_e'(br_tgt_sel)};
    assign mt = '{valid: mt_valid, dest: spr_sel_e'(mt_sel)};

    assign mt_link_hit  = mt.valid && (mt.dest == SPR_LINK);
    assign mt_count_hit = mt.valid && (mt.dest == SPR_COUNT);

    blcr_link_reg #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_link (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (br.valid && br.link),
        .cia     (cia),
        .mt_hit  (mt_link_hit),
        .mt_data (mt_data),
        .lr_q    (lr_q)
    );

    blcr_count_reg #(.XLEN(XLEN)) u_count (
        .clk        (clk),
        .rst        (rst),
        .dec_en     (br.valid && br.dec),
        .zero_sense (br.zero_sense),
        .mt_hit     (mt_count_hit),
        .mt_data    (mt_data),
        .ctr_q      (ctr_q),
        .ctr_ok     (ctr_ok)
    );

    blcr_target_sel #(.XLEN(XLEN)) u_tgt (
        .sel     (br.tgt),
        .lr_val  (lr_q),
        .ctr_val (ctr_q),
        .tgt     (tgt_addr)
    );

    p_both_update_r7: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_link && br_dec && !mt_valid)
        |=> (lr_q == $past(cia) + XLEN'(INSN_BYTES)) && (ctr_q == $past(ctr_q) - XLEN'(1)));
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (lr_q == '0) && (ctr_q == '0));
endmodule

// File: tb/blcr_unit_test.sv
module blcr_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid, br_link, br_dec, br_zero_sense, br_tgt_sel;
    logic [63:0] cia;
    logic        mt_valid, mt_sel;
    logic [63:0] mt_data;
    logic [63:0] lr_q, ctr_q, tgt_addr;
    logic        ctr_ok;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    logic [63:0] m_lr, m_ctr;

    always #5 clk = ~clk;

    blcr_unit uut (
        .clk(clk), .rst(rst),
        .br_valid(br_valid), .br_link(br_link), .br_dec(br_dec),
        .br_zero_sense(br_zero_sense), .br_tgt_sel(br_tgt_sel), .cia(cia),
        .mt_valid(mt_valid), .mt_sel(mt_sel), .mt_data(mt_data),
        .lr_q(lr_q), .ctr_q(ctr_q), .ctr_ok(ctr_ok), .tgt_addr(tgt_addr)
    );

    task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", what, got, exp);
        end
    endtask

    // one cycle: drive at negedge, compare, then advance the model at the edge
    task automatic cyc(input bit bv, input bit bl, input bit bd, input bit zs,
                       input bit ts, input logic [63:0] a,
                       input bit mv, input bit ms, input logic [63:0] d);
        logic [63:0] nl, nc, dec;
        bit          ok;
        br_valid = bv; br_link = bl; br_dec = bd; br_zero_sense = zs;
        br_tgt_sel = ts; cia = a; mt_valid = mv; mt_sel = ms; mt_data = d;
        #1;
        dec = m_ctr - 64'd1;
        ok  = (bv && bd) ? ((dec == 64'd0) == zs) : 1'b1;
        chk("lr_q R2 R5 R6 R7 R9", lr_q, m_lr);
        chk("ctr_q R3 R5 R6 R7 R9", ctr_q, m_ctr);
        chk("ctr_ok R4", {63'd0, ctr_ok}, {63'd0, ok});
        chk("tgt_addr R8", tgt_addr, ts ? m_ctr : m_lr);
        nl = m_lr; nc = m_ctr;
        if (bv && bl) nl = a + 64'd4;
        if (bv && bd) nc = dec;
        if (mv && !ms) nl = d;
        if (mv && ms)  nc = d;
        @(posedge clk);
        m_lr = nl; m_ctr = nc;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cyc(0,0,0,0,0,64'd0,0,0,64'd0);
        // reset clears even with writes requested
        rst = 1'b1;
        br_valid = 1; br_link = 1; br_dec = 1; mt_valid = 1; mt_data = '1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_lr = '0; m_ctr = '0;
        chk("lr_q R1 reset", lr_q, 64'd0);
        chk("ctr_q R1 reset", ctr_q, 64'd0);

        // R3 wrap from zero, R4 nonzero sense
        cyc(1,0,1,0,1,64'h10,0,0,64'd0);
        // R5 loads
        cyc(0,0,0,0,0,64'd0,1,1,64'd2);
        cyc(0,0,0,0,0,64'd0,1,0,64'hdead_beef_0000_1000);
        // R4 zero sense: counter 2 -> 1 not zero, then 1 -> 0 zero
        cyc(1,0,1,1,0,64'h200,0,0,64'd0);
        cyc(1,0,1,1,1,64'h204,0,0,64'd0);
        // R9 ignored bits with br_valid=0
        cyc(0,1,1,0,0,64'h300,0,0,64'd0);
        cyc(0,0,0,0,1,64'h304,0,0,64'd0);
        // R7 combined with counter at 1
        cyc(0,0,0,0,0,64'd0,1,1,64'd1);
        cyc(1,1,1,1,0,64'h1000,0,0,64'd0);
        // R6 move-to beats branch on each register, other still updated
        cyc(1,1,1,0,0,64'h2000,1,1,64'd1);
        cyc(1,1,1,1,1,64'h3000,1,0,64'h4444);
        // R2 wrap of cia+4
        cyc(1,1,0,0,0,64'hffff_ffff_ffff_fffc,0,0,64'd0);
        cyc(0,0,0,0,0,64'd0,0,0,64'd0);

        for (int i = 0; i < 3000; i++) begin
            logic [63:0] d;
            int unsigned r;
            r = $urandom;
            d = (r[3:2] == 2'b00) ? {$urandom, $urandom} : 64'(r[5:4]);
            cyc(r[6], r[7], r[8], r[9], r[10], {$urandom, $urandom},
                r[11] & r[12], r[13], d);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule